// File: doc/BRIEF.md
# Main-Road / Side-Road Traffic Light Controller

This block sequences the lamps of an intersection where a busy main road crosses a lightly used side road. A single sensor input reports that a vehicle is waiting on the side road. While nobody waits there, the main road keeps its green. When a vehicle is detected, the main road must first have held green for a minimum time. Only then does it step through yellow to red, and the side road receives green.

The side-road green lasts only while a vehicle remains detected, and never beyond the long interval. After that, the side road steps through yellow back to red and the main road returns to green. An internal interval timer provides the two durations: a short one for yellow phases and a long one for green phases. Both durations are parameters counted in clock cycles. The timer is restarted on every phase change, so each phase is timed from its own entry.

Top module: `tl_intersection_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the main road shows green and the side road shows red, with the phase timer at zero.
- R2: With the sensor input low, the main road stays green for any number of cycles.
- R3: The main green phase is left only when the sensor is high in a cycle in which at least LONG_CYCLES cycles have passed since the phase began. With the sensor held high from entry, main green therefore lasts exactly LONG_CYCLES+1 cycles.
- R4: The main yellow phase lasts exactly SHORT_CYCLES+1 cycles and is always followed by side green.
- R5: The side green phase is left in the cycle after the sensor is sampled low, or after LONG_CYCLES+1 cycles if the sensor stays high. It is always followed by side yellow.
- R6: The side yellow phase lasts exactly SHORT_CYCLES+1 cycles and is always followed by main green.
- R7: Every phase change restarts the timer, so a phase that was cut short leaves the following phase with its full duration.
- R8: For each road exactly one of green, yellow and red is lit in every cycle, and at least one of the two roads shows red.
- R9: Once main green has lasted LONG_CYCLES cycles, the timer holds its expired state. A vehicle that arrives later then ends main green one cycle after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| car_waiting | input | 1 | High while a vehicle is detected on the side road |
| main_green | output | 1 | Main-road green lamp |
| main_yellow | output | 1 | Main-road yellow lamp |
| main_red | output | 1 | Main-road red lamp |
| side_green | output | 1 | Side-road green lamp |
| side_yellow | output | 1 | Side-road yellow lamp |
| side_red | output | 1 | Side-road red lamp |

## Verification
Several sensor patterns are applied.

- **Long idle stretch with the sensor low:** separates a controller that holds main green from one that cycles on a timer alone.
- **Sensor held high from reset:** measures every phase length. This exposes off-by-one errors in the short and long limits.
- **Short vehicle pulse during side green:** shows that side green ends early while the following yellow still runs its full length. This is the restart behaviour.
- **Sensor toggling during the minimum main green:** confirms the main road does not yield early.
- **Vehicle arriving long after the main green limit:** confirms the saturated timer gives a one-cycle response.

// File: rtl/tl_pkg.sv
package tl_pkg;

    typedef enum logic [1:0] {
        PH_MAIN_GO   = 2'd0,
        PH_MAIN_WARN = 2'd1,
        PH_SIDE_GO   = 2'd2,
        PH_SIDE_WARN = 2'd3
    } phase_e;

    typedef struct packed {
        logic green;
        logic yellow;
        logic red;
    } lamp_t;

endpackage

// File: rtl/tl_interval_timer.sv
module tl_interval_timer #(
    parameter int SHORT_CYCLES = 3,
    parameter int LONG_CYCLES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic short_done,
    output logic long_done
);
    localparam int CNT_W = $clog2(LONG_CYCLES + 1);
    localparam logic [CNT_W-1:0] SHORT_LIM = SHORT_CYCLES[CNT_W-1:0];
    localparam logic [CNT_W-1:0] LONG_LIM  = LONG_CYCLES[CNT_W-1:0];

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.count = '0;
        end else if (tmr_q.count != LONG_LIM) begin
            tmr_d.count = tmr_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign short_done = (tmr_q.count >= SHORT_LIM);
    assign long_done  = (tmr_q.count >= LONG_LIM);

    // R7: a restart strobe leaves the count at zero in the next cycle
    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tmr_q.count == '0));

    // R9: the expired state holds until the next restart
    a_r9_long_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (long_done && !restart) |=> long_done);

    // R3: the short limit is reached no later than the long one
    a_r3_short_before_long: assert property (@(posedge clk) disable iff (!rst_n)
        long_done |-> short_done);

endmodule

// File: rtl/tl_phase_fsm.sv
module tl_phase_fsm
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   car,
    input  logic   short_done,
    input  logic   long_done,
    output phase_e phase,
    output logic   restart
);
    typedef struct packed {
        phase_e phase;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.phase)
            PH_MAIN_GO:   if (car && long_done)  fsm_d.phase = PH_MAIN_WARN;
            PH_MAIN_WARN: if (short_done)        fsm_d.phase = PH_SIDE_GO;
            PH_SIDE_GO:   if (!car || long_done) fsm_d.phase = PH_SIDE_WARN;
            PH_SIDE_WARN: if (short_done)        fsm_d.phase = PH_MAIN_GO;
            default:                             fsm_d.phase = PH_MAIN_GO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.phase <= PH_MAIN_GO;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign phase   = fsm_q.phase;
    assign restart = (fsm_d.phase != fsm_q.phase);

    // R3: main green ends only after a car was seen with the long interval expired
    a_r3_main_exit_guard: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.phase) == PH_MAIN_GO && fsm_q.phase != PH_MAIN_GO)
            |-> ($past(car && long_done) && fsm_q.phase == PH_MAIN_WARN));

    // R4: main yellow hands over to side green once the short interval is done
    a_r4_main_warn_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.phase) == PH_MAIN_WARN && fsm_q.phase != PH_MAIN_WARN)
            |-> ($past(short_done) && fsm_q.phase == PH_SIDE_GO));

    // R5: side green only ever moves on to side yellow
    a_r5_side_go_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.phase) == PH_SIDE_GO && fsm_q.phase != PH_SIDE_GO)
            |-> (fsm_q.phase == PH_SIDE_WARN));

    // R5: an absent car forces side green to end
    a_r5_side_go_no_car: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.phase == PH_SIDE_GO && !car) |=> (fsm_q.phase == PH_SIDE_WARN));

    // R6: side yellow returns to main green after the short interval
    a_r6_side_warn_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.phase) == PH_SIDE_WARN && fsm_q.phase != PH_SIDE_WARN)
            |-> ($past(short_done) && fsm_q.phase == PH_MAIN_GO));

    // R2: without a car the main green phase persists
    a_r2_main_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.phase == PH_MAIN_GO && !car) |=> (fsm_q.phase == PH_MAIN_GO));

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
    import tl_pkg::*;
(
    input  phase_e phase,
    output lamp_t  main_lamp,
    output lamp_t  side_lamp
);
    always_comb begin
        main_lamp = '{green: 1'b0, yellow: 1'b0, red: 1'b1};
        side_lamp = '{green: 1'b0, yellow: 1'b0, red: 1'b1};
        unique case (phase)
            PH_MAIN_GO:   main_lamp = '{green: 1'b1, yellow: 1'b0, red: 1'b0};
            PH_MAIN_WARN: main_lamp = '{green: 1'b0, yellow: 1'b1, red: 1'b0};
            PH_SIDE_GO:   side_lamp = '{green: 1'b1, yellow: 1'b0, red: 1'b0};
            PH_SIDE_WARN: side_lamp = '{green: 1'b0, yellow: 1'b1, red: 1'b0};
            default: ;
        endcase
    end
endmodule

// File: rtl/tl_intersection_ctrl.sv
module tl_intersection_ctrl
    import tl_pkg::*;
#(
    parameter int SHORT_CYCLES = 3,
    parameter int LONG_CYCLES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic car_waiting,
    output logic main_green,
    output logic main_yellow,
    output logic main_red,
    output logic side_green,
    output logic side_yellow,
    output logic side_red
);
    phase_e phase;
    logic   restart;
    logic   short_done;
    logic   long_done;
    lamp_t  main_lamp;
    lamp_t  side_lamp;

    tl_interval_timer #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .short_done (short_done),
        .long_done  (long_done)
    );

    tl_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .car        (car_waiting),
        .short_done (short_done),
        .long_done  (long_done),
        .phase      (phase),
        .restart    (restart)
    );

    tl_lamp_decode u_decode (
        .phase     (phase),
        .main_lamp (main_lamp),
        .side_lamp (side_lamp)
    );

    assign main_green  = main_lamp.green;
    assign main_yellow = main_lamp.yellow;
    assign main_red    = main_lamp.red;
    assign side_green  = side_lamp.green;
    assign side_yellow = side_lamp.yellow;
    assign side_red    = side_lamp.red;

    // R8: one lamp per road, and never two roads without red
    a_r8_main_one_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({main_green, main_yellow, main_red}) == 1);
    a_r8_side_one_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({side_green, side_yellow, side_red}) == 1);
    a_r8_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (main_red || side_red));

    // R7: a change of lamps is always followed by a freshly started timer
    a_r7_fresh_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(main_green) != main_green) |-> (!short_done && !long_done));

endmodule

// File: tb/tl_intersection_ctrl_tb.sv
module tl_intersection_ctrl_tb;
    localparam int SHORT = 3;
    localparam int LONG  = 8;

    typedef struct {
        logic [5:0] lamps;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic car = 1'b0;
    logic mg, my, mr, sg, sy, sr;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   cycles = 0;
    int   model_ph = 0;
    int   model_el = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    tl_intersection_ctrl #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) u_dut (
        .clk (clk), .rst_n (rst_n), .car_waiting (car),
        .main_green (mg), .main_yellow (my), .main_red (mr),
        .side_green (sg), .side_yellow (sy), .side_red (sr)
    );

    function automatic logic [5:0] lamps_of(int ph);
        case (ph)
            0:       return 6'b100_001;
            1:       return 6'b010_001;
            2:       return 6'b001_100;
            default: return 6'b001_010;
        endcase
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // driver: push expectation of the current cycle, drive input, advance model
    task automatic step(input logic c, input string req);
        exp_t e;
        int   nx;
        e.lamps = lamps_of(model_ph);
        e.req   = req;
        exp_q.push_back(e);
        car = c;
        nx = model_ph;
        case (model_ph)
            0: if (c && model_el >= LONG)  nx = 1;
            1: if (model_el >= SHORT)      nx = 2;
            2: if (!c || model_el >= LONG) nx = 3;
            default: if (model_el >= SHORT) nx = 0;
        endcase
        if (nx != model_ph) model_el = 0;
        else if (model_el < LONG) model_el = model_el + 1;
        model_ph = nx;
        @(negedge clk);
    endtask

    task automatic run(input logic c, input int n, input string req);
        for (int i = 0; i < n; i++) step(c, req);
    endtask

    // monitor: pop and compare, plus the lamp-safety check every cycle
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if ({mg, my, mr, sg, sy, sr} !== e.lamps) begin
                n_fail++;
                $display("FAIL %s: lamps actual %b expected %b at t=%0t",
                         e.req, {mg, my, mr, sg, sy, sr}, e.lamps, $time);
            end
            n_checks++;
            if (($countones({mg, my, mr}) != 1) || ($countones({sg, sy, sr}) != 1) || (!mr && !sr)) begin
                n_fail++;
                $display("FAIL R8: lamps actual %b expected one per road with a red", {mg, my, mr, sg, sy, sr});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected at most 200000", cycles);
            summary();
        end
    end

    initial begin
        rst_n = 1'b0;
        car = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            #2;
            n_checks++;
            if ({mg, my, mr, sg, sy, sr} !== 6'b100_001) begin
                n_fail++;
                $display("FAIL R1: lamps in reset actual %b expected %b", {mg, my, mr, sg, sy, sr}, 6'b100_001);
            end
            @(negedge clk);
        end
        car = 1'b0;
        rst_n = 1'b1;
        model_ph = 0;
        model_el = 0;
        step(1'b0, "R1");
        run(1'b0, 40, "R2");
        run(1'b1, 2 * LONG + 2 * SHORT + 8, "R3_R4_R5_R6");
        run(1'b1, 30, "R3");
        run(1'b0, 20, "R5");
        run(1'b1, LONG + 1, "R9");
        run(1'b1, SHORT + 3, "R4");
        run(1'b0, 1, "R5");
        run(1'b1, SHORT + 4, "R7");
        for (int k = 0; k < 6; k++) begin
            step(1'b1, "R3");
            step(1'b0, "R3");
        end
        run(1'b0, 30, "R2");
        run(1'b1, 3 * (LONG + SHORT + 2), "R6");
        run(1'b0, 20, "R9");
        step(1'b1, "R9");
        run(1'b1, 4, "R9");
        run(1'b0, 20, "R7");
        @(negedge clk);
        #4;
        summary();
    end
endmodule